// File: doc/BRIEF.md
# Serial Line Receiver with Break-Gated Receive Queue

This block turns a single asynchronous serial line into bytes. It counts a 16x oversampling enable pulse from outside. It confirms a start bit at its midpoint and samples each later bit at its centre. It gathers the data bits least significant first, and then it takes an optional even or odd parity bit and one or two stop bits. Every completed frame is checked and written into a 16-entry queue. Each entry keeps its own framing-error and parity-error tag, and the tags of the head entry are shown next to its data.

Three sticky flags report the receiver state: data ready, receive error and line break. Clearing a flag takes two steps. A flag read strobe first captures which flags are currently 1. A later flag write then clears each captured flag whose write bit is 0. A line held low for a whole frame, stop position included, is a break. That all-zero frame is still queued with its framing tag. No frame enters the queue after it while the break flag stays set.

Top module: `uart_brk_rx`

## Requirements
- R1: A start is accepted only on a low line after the line was sampled high while idle. The start is confirmed on the 8th enable tick. If the line reads 1 there, the start is dropped as a glitch and nothing is queued.
- R2: Data bits are sampled 16 ticks apart at bit centres and are assembled least significant bit first, so bit 0 of `rd_data` is the first data bit on the line.
- R3: When `cfg_par_en` is 1, a parity bit follows the data. `cfg_par_odd`=0 requires an even number of ones over data plus parity, and 1 requires an odd number. A mismatch sets the entry's `rd_per` tag. With parity off the tag is 0.
- R4: Only the first stop bit is checked. If it reads 0, the entry's `rd_fer` tag is set. With `cfg_two_stop`=1 the value of the second stop bit has no effect.
- R5: The queue holds 16 entries in arrival order. `rd_pop` removes the head, `fifo_count` gives the occupancy, and `fifo_full` and `fifo_empty` follow it. A pop on an empty queue has no effect.
- R6: A frame that completes while the queue is full is discarded, the queue contents stay unchanged, and the receive-error flag is set.
- R7: Queuing a frame with a framing or parity tag sets the receive-error flag.
- R8: A frame whose data, parity and first stop bit all read 0 sets the break flag. That frame is still queued as 0x00 with `rd_fer`=1.
- R9: While the break flag is set, completed frames are discarded and no entry is written.
- R10: A clear request for the break flag has no effect while the synchronised line is low.
- R11: Flag bits in `flag_wr_data` are: bit 0 data ready, bit 1 receive error, bit 2 break. A write clears a flag only when that flag was 1 at the most recent `flag_rd` and its write bit is 0. Writing 1 never clears a flag, and every write disarms all flags. Setting a flag takes priority over clearing it.
- R12: Data ready is set on every cycle in which `fifo_count` >= `cfg_thresh` and `cfg_thresh` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_two_stop | input | 1 | Two stop bits |
| cfg_thresh | input | 5 | Data-ready occupancy threshold, 0 disables |
| rd_pop | input | 1 | Remove the head entry |
| rd_data | output | 8 | Head entry data |
| rd_fer | output | 1 | Head entry framing-error tag |
| rd_per | output | 1 | Head entry parity-error tag |
| fifo_full | output | 1 | Queue holds 16 entries |
| fifo_empty | output | 1 | Queue holds no entry |
| fifo_count | output | 5 | Queue occupancy |
| flag_rd | input | 1 | Capture which flags are set (arms clearing) |
| flag_wr | input | 1 | Flag write strobe |
| flag_wr_data | input | 3 | Flag write value, a 0 clears an armed flag |
| flag_dr | output | 1 | Data ready flag |
| flag_er | output | 1 | Receive error flag |
| flag_brk | output | 1 | Break flag |

## Verification
The assertions check four rules on every cycle: no write is taken while the queue is full or while the break flag is set, data ready follows the threshold, the receive-error flag falls only after a write with its bit at 0, and the break flag falls only while the line is high. Other behaviour can only be shown by the bench's scenarios: least-significant-first assembly, parity in both senses, the unchecked second stop bit, glitch rejection, overflow discard, and the stored all-zero break entry. These depend on whole serial frames, which the bench builds and compares against its own queue model.

// File: rtl/uart_brk_rx_pkg.sv
package uart_brk_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP1,
    RX_STOP2
  } rx_state_e;

  localparam int FLG_DR  = 0;
  localparam int FLG_ER  = 1;
  localparam int FLG_BRK = 2;
  localparam int FLG_N   = 3;

endpackage

// File: rtl/uart_brk_rx_sampler.sv
module uart_brk_rx_sampler
  import uart_brk_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              two_stop,
  output logic              line_s,
  output logic              frm_done,
  output logic [DATA_W-1:0] frm_data,
  output logic              frm_fer,
  output logic              frm_per,
  output logic              frm_zero
);
  localparam int CW = $clog2(OVS);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] MID  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [BW-1:0] TOPB = BW'(DATA_W - 1);

  logic              sync1_q, sync2_q;
  rx_state_e         st_q, st_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic [BW-1:0]     bit_q, bit_n;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic              par_q, par_n;
  logic              zero_q, zero_n;
  logic              per_q, per_n;
  logic              rdy_q, rdy_n;
  logic              at_mid, at_end;

  // two-flop synchroniser, idle high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
    end else begin
      sync1_q <= rxd;
      sync2_q <= sync1_q;
    end
  end
  assign line_s = sync2_q;

  assign at_mid = tick && (cnt_q == MID);
  assign at_end = tick && (cnt_q == LAST);

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    bit_n  = bit_q;
    sh_n   = sh_q;
    par_n  = par_q;
    zero_n = zero_q;
    per_n  = per_q;
    rdy_n  = rdy_q;
    if (tick) begin
      unique case (st_q)
        RX_IDLE: begin
          if (line_s) begin
            rdy_n = 1'b1;
          end else if (rdy_q) begin
            st_n  = RX_START;
            cnt_n = '0;
            rdy_n = 1'b0;
          end
        end
        RX_START: begin
          if (at_mid) begin
            cnt_n = '0;
            if (line_s) begin
              st_n  = RX_IDLE;
              rdy_n = 1'b1;
            end else begin
              st_n   = RX_DATA;
              bit_n  = '0;
              par_n  = 1'b0;
              zero_n = 1'b1;
              per_n  = 1'b0;
            end
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (at_end) begin
            cnt_n  = '0;
            sh_n   = {line_s, sh_q[DATA_W-1:1]};
            par_n  = par_q ^ line_s;
            zero_n = zero_q & ~line_s;
            if (bit_q == TOPB) st_n = par_en ? RX_PAR : RX_STOP1;
            else               bit_n = bit_q + 1'b1;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        RX_PAR: begin
          if (at_end) begin
            cnt_n  = '0;
            per_n  = par_q ^ line_s ^ par_odd;
            zero_n = zero_q & ~line_s;
            st_n   = RX_STOP1;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        RX_STOP1: begin
          if (at_end) begin
            cnt_n = '0;
            if (two_stop) begin
              st_n = RX_STOP2;
            end else begin
              st_n  = RX_IDLE;
              rdy_n = line_s;
            end
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        RX_STOP2: begin
          if (at_end) begin
            cnt_n = '0;
            st_n  = RX_IDLE;
            rdy_n = line_s;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        default: st_n = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      par_q  <= 1'b0;
      zero_q <= 1'b0;
      per_q  <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      bit_q  <= bit_n;
      sh_q   <= sh_n;
      par_q  <= par_n;
      zero_q <= zero_n;
      per_q  <= per_n;
      rdy_q  <= rdy_n;
    end
  end

  // frame result is presented in the cycle the first stop bit is sampled
  assign frm_done = at_end && (st_q == RX_STOP1);
  assign frm_data = sh_q;
  assign frm_per  = per_q;
  assign frm_fer  = ~line_s;
  assign frm_zero = zero_q & ~line_s;

endmodule

// File: rtl/uart_brk_rx_fifo.sv
module uart_brk_rx_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LASTP = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = cnt_q;
    if (do_push) wp_n = (wp_q == LASTP) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_n = (rp_q == LASTP) ? '0 : rp_q + 1'b1;
    unique case ({do_push, do_pop})
      2'b10:   cnt_n = cnt_q + 1'b1;
      2'b01:   cnt_n = cnt_q - 1'b1;
      default: cnt_n = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  // storage array carries no reset
  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  assign rdata = mem[rp_q];
  assign count = cnt_q;

endmodule

// File: rtl/uart_brk_rx_flags.sv
module uart_brk_rx_flags
  import uart_brk_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FLG_N-1:0] set,
  input  logic             line_s,
  input  logic             rd,
  input  logic             wr,
  input  logic [FLG_N-1:0] wr_data,
  output logic [FLG_N-1:0] flags
);
  logic [FLG_N-1:0] flg_q, flg_n, arm_q, arm_n, clr;

  always_comb begin
    for (int i = 0; i < FLG_N; i++) begin
      clr[i] = wr && !wr_data[i] && arm_q[i];
    end
    clr[FLG_BRK] = clr[FLG_BRK] && line_s;
    flg_n = set | (flg_q & ~clr);
    if (rd)      arm_n = flg_q;
    else if (wr) arm_n = '0;
    else         arm_n = arm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '0;
      arm_q <= '0;
    end else begin
      flg_q <= flg_n;
      arm_q <= arm_n;
    end
  end

  assign flags = flg_q;

endmodule

// File: rtl/uart_brk_rx.sv
module uart_brk_rx
  import uart_brk_rx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int OVS        = 16,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rxd,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  input  logic [CNT_W-1:0]  cfg_thresh,
  input  logic              rd_pop,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_fer,
  output logic              rd_per,
  output logic              fifo_full,
  output logic              fifo_empty,
  output logic [CNT_W-1:0]  fifo_count,
  input  logic              flag_rd,
  input  logic              flag_wr,
  input  logic [2:0]        flag_wr_data,
  output logic              flag_dr,
  output logic              flag_er,
  output logic              flag_brk
);
  localparam int ENT_W = DATA_W + 2;

  logic              line_s;
  logic              frm_done, frm_fer, frm_per, frm_zero;
  logic [DATA_W-1:0] frm_data;
  logic              push;
  logic [ENT_W-1:0]  head;
  logic [FLG_N-1:0]  flg_set, flags;

  uart_brk_rx_sampler #(.DATA_W(DATA_W), .OVS(OVS)) u_samp (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick16),
    .rxd      (rxd),
    .par_en   (cfg_par_en),
    .par_odd  (cfg_par_odd),
    .two_stop (cfg_two_stop),
    .line_s   (line_s),
    .frm_done (frm_done),
    .frm_data (frm_data),
    .frm_fer  (frm_fer),
    .frm_per  (frm_per),
    .frm_zero (frm_zero)
  );

  // writes are held off while break is flagged or the queue is full
  assign push = frm_done && !flags[FLG_BRK] && !fifo_full;

  uart_brk_rx_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .wdata ({frm_fer, frm_per, frm_data}),
    .pop   (rd_pop),
    .rdata (head),
    .count (fifo_count),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  always_comb begin
    flg_set          = '0;
    flg_set[FLG_DR]  = (cfg_thresh != '0) && (fifo_count >= cfg_thresh);
    flg_set[FLG_ER]  = frm_done && !flags[FLG_BRK] && (fifo_full || frm_fer || frm_per);
    flg_set[FLG_BRK] = frm_done && frm_zero;
  end

  uart_brk_rx_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set     (flg_set),
    .line_s  (line_s),
    .rd      (flag_rd),
    .wr      (flag_wr),
    .wr_data (flag_wr_data),
    .flags   (flags)
  );

  assign rd_data  = head[DATA_W-1:0];
  assign rd_per   = head[DATA_W];
  assign rd_fer   = head[DATA_W+1];
  assign flag_dr  = flags[FLG_DR];
  assign flag_er  = flags[FLG_ER];
  assign flag_brk = flags[FLG_BRK];

endmodule

// File: rtl/uart_brk_rx_chk.sv
module uart_brk_rx_chk #(
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_pop,
  input logic [CNT_W-1:0] cfg_thresh,
  input logic [CNT_W-1:0] fifo_count,
  input logic             fifo_full,
  input logic             flag_wr,
  input logic [2:0]       flag_wr_data,
  input logic             flag_dr,
  input logic             flag_er,
  input logic             flag_brk,
  input logic             line_s
);

  // R5 / R6: a full queue without a pop stays full
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full && !rd_pop |=> fifo_full);

  // R9: no entry is added while break is flagged
  assert_brk_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_brk && !rd_pop |=> fifo_count <= $past(fifo_count));

  // R12: occupancy at threshold raises data ready
  assert_dr_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_thresh != '0) && (fifo_count >= cfg_thresh) |=> flag_dr);

  // R11: receive error falls only after a write with its bit at 0
  assert_er_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_er) |-> $past(flag_wr) && !$past(flag_wr_data[1]));

  // R10: break falls only while the line is high
  assert_brk_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_brk) |-> $past(line_s));

endmodule

bind uart_brk_rx uart_brk_rx_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_pop       (rd_pop),
  .cfg_thresh   (cfg_thresh),
  .fifo_count   (fifo_count),
  .fifo_full    (fifo_full),
  .flag_wr      (flag_wr),
  .flag_wr_data (flag_wr_data),
  .flag_dr      (flag_dr),
  .flag_er      (flag_er),
  .flag_brk     (flag_brk),
  .line_s       (line_s)
);

// File: tb/uart_brk_rx_tb.sv
module uart_brk_rx_tb;
  localparam int BITC = 64;   // 16 ticks x 4 clocks

  logic       clk, rst_n, tick16, rxd;
  logic       cfg_par_en, cfg_par_odd, cfg_two_stop;
  logic [4:0] cfg_thresh;
  logic       rd_pop;
  logic [7:0] rd_data;
  logic       rd_fer, rd_per, fifo_full, fifo_empty;
  logic [4:0] fifo_count;
  logic       flag_rd, flag_wr;
  logic [2:0] flag_wr_data;
  logic       flag_dr, flag_er, flag_brk;

  int n_chk = 0;
  int n_fail = 0;
  bit ended = 0;
  logic [9:0] q[$];   // model queue {fer, per, data}
  bit exp_brk = 0;
  bit exp_er  = 0;
  int tdiv = 0;

  uart_brk_rx u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
    .cfg_thresh(cfg_thresh), .rd_pop(rd_pop), .rd_data(rd_data), .rd_fer(rd_fer),
    .rd_per(rd_per), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .fifo_count(fifo_count), .flag_rd(flag_rd), .flag_wr(flag_wr),
    .flag_wr_data(flag_wr_data), .flag_dr(flag_dr), .flag_er(flag_er),
    .flag_brk(flag_brk)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) begin
    tdiv   = (tdiv == 3) ? 0 : tdiv + 1;
    tick16 = (tdiv == 0);
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // head of queue compared with the model every clock (R5)
  always @(posedge clk) begin
    #5;
    if (rst_n && !ended && !fifo_empty && q.size() > 0)
      chk("R5 head entry", {rd_fer, rd_per, rd_data}, q[0]);
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic drive_bit(input logic b);
    rxd = b;
    repeat (BITC) @(negedge clk);
  endtask

  task automatic model_frame(input logic [7:0] d, input logic fer, input logic per, input logic zero);
    if (exp_brk) return;
    if (q.size() == 16) exp_er = 1;
    else begin
      q.push_back({fer, per, d});
      if (fer || per) exp_er = 1;
    end
    if (zero) exp_brk = 1;
  endtask

  task automatic send(input logic [7:0] d, input logic pe, input logic odd, input logic two,
                      input logic badp, input logic s1, input logic s2);
    cfg_par_en = pe; cfg_par_odd = odd; cfg_two_stop = two;
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    if (pe) drive_bit((^d) ^ odd ^ badp);
    drive_bit(s1);
    if (two) drive_bit(s2);
    drive_bit(1'b1);
    model_frame(d, !s1, pe & badp, 1'b0);
  endtask

  task automatic pop1();
    @(negedge clk);
    rd_pop = 1'b1;
    if (q.size() > 0) void'(q.pop_front());
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  task automatic frd();
    @(negedge clk); flag_rd = 1'b1;
    @(negedge clk); flag_rd = 1'b0;
  endtask

  task automatic fwr(input logic [2:0] v);
    @(negedge clk); flag_wr = 1'b1; flag_wr_data = v;
    @(negedge clk); flag_wr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic drain();
    while (!fifo_empty) pop1();
    q.delete();
  endtask

  initial begin
    rst_n = 0; rxd = 1; tick16 = 0; cfg_par_en = 0; cfg_par_odd = 0; cfg_two_stop = 0;
    cfg_thresh = 5'd0; rd_pop = 0; flag_rd = 0; flag_wr = 0; flag_wr_data = 3'b111;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (BITC) @(negedge clk);

    chk("R5 reset empty", fifo_empty, 1);
    chk("R5 reset count", fifo_count, 0);
    chk("R11 reset flags", {flag_brk, flag_er, flag_dr}, 0);

    // R2: LSB first
    send(8'hA5, 0, 0, 0, 0, 1, 1);
    chk("R2 data lsb first", rd_data, 8'hA5);
    chk("R5 count one", fifo_count, 1);
    send(8'h01, 0, 0, 0, 0, 1, 1);
    chk("R2 second frame count", fifo_count, 2);
    pop1(); @(negedge clk);
    chk("R2 head after pop", rd_data, 8'h01);
    pop1(); @(negedge clk);
    chk("R5 empty after pops", fifo_empty, 1);
    pop1(); @(negedge clk);
    chk("R5 pop on empty", fifo_count, 0);

    // R3: parity
    send(8'h37, 1, 0, 0, 0, 1, 1);
    chk("R3 even ok per", rd_per, 0);
    pop1();
    send(8'h37, 1, 1, 0, 0, 1, 1);
    @(negedge clk);
    chk("R3 odd ok per", rd_per, 0);
    pop1();
    send(8'h5C, 1, 1, 0, 1, 1, 1);
    @(negedge clk);
    chk("R3 odd bad per", rd_per, 1);
    chk("R7 er after parity error", flag_er, 1);
    pop1();

    // R11: clear protocol on ER
    fwr(3'b000);
    chk("R11 write without read keeps er", flag_er, 1);
    frd(); fwr(3'b111);
    chk("R11 write one keeps er", flag_er, 1);
    frd(); fwr(3'b101);
    chk("R11 armed zero clears er", flag_er, 0);

    // R4: only first stop checked
    send(8'h6E, 0, 0, 1, 0, 1, 0);
    @(negedge clk);
    chk("R4 second stop ignored fer", rd_fer, 0);
    chk("R4 no er", flag_er, 0);
    pop1();
    send(8'h81, 0, 0, 1, 0, 0, 1);
    @(negedge clk);
    chk("R4 first stop low fer", rd_fer, 1);
    chk("R7 er after framing error", flag_er, 1);
    pop1();
    frd(); fwr(3'b000);

    // R1: glitch
    rxd = 0; repeat (12) @(negedge clk);
    drive_bit(1'b1); drive_bit(1'b1);
    chk("R1 glitch rejected", fifo_count, 0);

    // R12: threshold
    cfg_thresh = 5'd4;
    for (int i = 0; i < 3; i++) send(8'h10 + 8'(i), 0, 0, 0, 0, 1, 1);
    chk("R12 below threshold", flag_dr, 0);
    send(8'h13, 0, 0, 0, 0, 1, 1);
    chk("R12 at threshold", flag_dr, 1);
    drain();
    cfg_thresh = 5'd0;
    frd(); fwr(3'b000);
    chk("R12 dr cleared when below", flag_dr, 0);

    // R6: overflow
    for (int i = 0; i < 16; i++) send(8'h40 + 8'(i), 0, 0, 0, 0, 1, 1);
    chk("R5 full", fifo_full, 1);
    chk("R6 no er before overflow", flag_er, 0);
    send(8'hEE, 0, 0, 0, 0, 1, 1);
    chk("R6 count stays", fifo_count, 16);
    chk("R6 er on overflow", flag_er, exp_er);
    chk("R6 head unchanged", rd_data, 8'h40);
    while (!fifo_empty) pop1();
    chk("R6 dropped frame absent", q.size(), 0);
    frd(); fwr(3'b000);

    // R8 / R9 / R10: break
    rxd = 0;
    repeat (20 * BITC) @(negedge clk);
    model_frame(8'h00, 1, 0, 1);
    chk("R8 break flag", flag_brk, 1);
    chk("R8 zero entry stored", fifo_count, 1);
    chk("R8 zero entry fer", {rd_fer, rd_per, rd_data}, 10'h200);
    frd(); fwr(3'b000);
    chk("R10 clear ignored while low", flag_brk, 1);
    drive_bit(1'b1); drive_bit(1'b1);
    send(8'h3C, 0, 0, 0, 0, 1, 1);
    chk("R9 frame dropped in break", fifo_count, 1);
    frd(); fwr(3'b000);
    chk("R10 clear after line high", flag_brk, 0);
    exp_brk = 0;
    send(8'h3C, 0, 0, 0, 0, 1, 1);
    chk("R9 storing resumes", fifo_count, 2);
    pop1(); @(negedge clk);
    chk("R9 resumed entry", rd_data, 8'h3C);
    pop1();

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule